// File: doc/BRIEF.md
# Operand Dependency Hazard Detector

This block tells an issue stage whether the source operand of the instruction being issued now relies on the destination operand of the instruction issued one strobe earlier. Each operand is described by a valid bit, a two-bit addressing mode and a register index. The block keeps a one-deep history of the last issued destination descriptor. It compares the current source descriptor against that stored copy and raises a single flag.

The flag follows the pairing of addressing modes. An immediate or absolute-address source never conflicts. A register-direct source conflicts only with a register-direct destination that names the same register. A displaced source conflicts with a register-direct destination that names its base register. It also conflicts with any displaced destination, whatever the registers, so that a memory write completes before a memory read that may alias it.

The issue stage raises the issue strobe for one cycle per instruction, with that instruction's destination descriptor on the destination inputs. From the next cycle on, the stored copy is the reference. The flag itself is combinational and needs no clock edge to follow the source inputs.

Top module: `opdep_hazard`

## Requirements
- R1: While reset (rst_n low) is applied, and after it is released, the stored destination reads as absent (prev_valid = 0), and depend is 0 until a valid destination has been captured.
- R2: Modes are encoded in 2 bits: 00 immediate, 01 register direct, 10 register plus displacement, 11 absolute address. The register index is REG_W bits (5 by default). On a rising clock edge with issue = 1, prev_valid, prev_mode and prev_reg take the values of dst_valid, dst_mode and dst_reg.
- R3: On a rising clock edge with issue = 0, prev_valid, prev_mode and prev_reg keep their values.
- R4: depend is 0 whenever src_valid is 0 or prev_valid is 0, whatever the modes and registers.
- R5: A valid source in mode 00 (immediate) never raises depend.
- R6: A valid source in mode 01 raises depend against a stored mode-01 destination exactly when src_reg equals prev_reg.
- R7: A valid source in mode 01 never raises depend against a stored destination in mode 10, 11 or 00, even when the register indices match.
- R8: A valid source in mode 10 raises depend against a stored mode-01 destination exactly when the base register src_reg equals prev_reg. It never raises depend against a stored destination in mode 11 or 00.
- R9: A valid source in mode 10 paired with a valid stored destination in mode 10 always raises depend, whatever both register indices are.
- R10: A valid source in mode 11 (absolute address) never raises depend.
- R11: depend is combinational. A change on the source inputs is reflected on depend in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Issue strobe; captures the destination descriptor |
| dst_valid | input | 1 | Destination descriptor present |
| dst_mode | input | 2 | Destination addressing mode |
| dst_reg | input | REG_W | Destination register index |
| src_valid | input | 1 | Source descriptor present |
| src_mode | input | 2 | Source addressing mode |
| src_reg | input | REG_W | Source register or base register index |
| depend | output | 1 | Source depends on the stored destination |
| prev_valid | output | 1 | Stored destination present |
| prev_mode | output | 2 | Stored destination addressing mode |
| prev_reg | output | REG_W | Stored destination register index |

## Verification
The flag is tried with every source mode against every stored destination mode. Matching and differing register indices are used in each pairing, so that register-equality checks can be told apart from mode-only decisions. Two displaced operands are paired with unrelated registers, which separates the unconditional memory conflict from the base-register match. Absent descriptors on either side, the state just after reset, and cycles with the strobe low show that the flag is gated by presence and that the history changes only on issue.

// File: rtl/opdep_hazard.sv
module opdep_hazard #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             dst_valid,
  input  logic [1:0]       dst_mode,
  input  logic [REG_W-1:0] dst_reg,
  input  logic             src_valid,
  input  logic [1:0]       src_mode,
  input  logic [REG_W-1:0] src_reg,
  output logic             depend,
  output logic             prev_valid,
  output logic [1:0]       prev_mode,
  output logic [REG_W-1:0] prev_reg
);
  localparam logic [1:0] M_IMM = 2'b00;
  localparam logic [1:0] M_DIR = 2'b01;
  localparam logic [1:0] M_DSP = 2'b10;
  localparam logic [1:0] M_ABS = 2'b11;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_valid <= 1'b0;
      prev_mode  <= M_IMM;
      prev_reg   <= '0;
    end else if (issue) begin
      prev_valid <= dst_valid;
      prev_mode  <= dst_mode;
      prev_reg   <= dst_reg;
    end
  end

  logic same_reg;
  logic mode_hit;
  assign same_reg = (prev_reg == src_reg);

  always_comb begin
    unique case (src_mode)
      M_DIR:   mode_hit = (prev_mode == M_DIR) && same_reg;
      M_DSP:   mode_hit = ((prev_mode == M_DIR) && same_reg) || (prev_mode == M_DSP);
      default: mode_hit = 1'b0;
    endcase
  end

  assign depend = src_valid & prev_valid & mode_hit;

  // R2
  capture_on_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (prev_valid == $past(dst_valid)) && (prev_mode == $past(dst_mode))
              && (prev_reg == $past(dst_reg)));

  // R3
  hold_without_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(prev_valid) && $stable(prev_mode) && $stable(prev_reg));

  // R4
  absent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_valid || !prev_valid) |-> !depend);

  // R5
  imm_src_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_mode == M_IMM) |-> !depend);

  // R10
  abs_src_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_mode == M_ABS) |-> !depend);

  // R9
  mem_pair_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && prev_valid && src_mode == M_DSP && prev_mode == M_DSP) |-> depend);

  // R7
  dir_vs_mem_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_mode == M_DIR && prev_mode != M_DIR) |-> !depend);
endmodule

// File: tb/opdep_hazard_bench.sv
module opdep_hazard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             issue = 1'b0;
  logic             dst_valid = 1'b0;
  logic [1:0]       dst_mode = 2'b00;
  logic [REG_W-1:0] dst_reg = '0;
  logic             src_valid = 1'b0;
  logic [1:0]       src_mode = 2'b00;
  logic [REG_W-1:0] src_reg = '0;
  logic             depend;
  logic             prev_valid;
  logic [1:0]       prev_mode;
  logic [REG_W-1:0] prev_reg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opdep_hazard #(.REG_W(REG_W)) u_opdep_hazard (
    .clk(clk), .rst_n(rst_n), .issue(issue),
    .dst_valid(dst_valid), .dst_mode(dst_mode), .dst_reg(dst_reg),
    .src_valid(src_valid), .src_mode(src_mode), .src_reg(src_reg),
    .depend(depend), .prev_valid(prev_valid), .prev_mode(prev_mode), .prev_reg(prev_reg)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic put_dst(input bit v, input logic [1:0] m, input int r);
    @(negedge clk);
    dst_valid = v; dst_mode = m; dst_reg = REG_W'(r); issue = 1'b1;
    @(posedge clk); #1;
    issue = 1'b0;
  endtask

  task automatic probe(input string req, input bit v, input logic [1:0] m, input int r, input bit exp);
    src_valid = v; src_mode = m; src_reg = REG_W'(r);
    #1;
    chk(req, depend, exp);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 prev_valid in reset", prev_valid, 0);
    probe("R1 depend in reset", 1, 2'b10, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 prev_valid after reset", prev_valid, 0);
    probe("R1 depend after reset", 1, 2'b01, 0, 0);
  endtask

  task automatic t_capture_hold;
    put_dst(1, 2'b10, 13);
    chk("R2 prev_valid", prev_valid, 1);
    chk("R2 prev_mode", prev_mode, 2'b10);
    chk("R2 prev_reg", prev_reg, 13);
    @(negedge clk);
    dst_valid = 1; dst_mode = 2'b01; dst_reg = 5'd3;
    repeat (2) @(posedge clk);
    #1;
    chk("R3 prev_mode held", prev_mode, 2'b10);
    chk("R3 prev_reg held", prev_reg, 13);
    probe("R3 direct src vs held displaced", 1, 2'b01, 3, 0);
  endtask

  task automatic t_absent;
    put_dst(0, 2'b10, 7);
    probe("R4 absent dst, displaced src", 1, 2'b10, 7, 0);
    put_dst(1, 2'b01, 7);
    probe("R4 absent src", 0, 2'b01, 7, 0);
    probe("R4 present src sanity", 1, 2'b01, 7, 1);
  endtask

  task automatic t_imm_abs;
    for (int m = 0; m < 4; m++) begin
      put_dst(1, 2'(m), 9);
      probe("R5 immediate src", 1, 2'b00, 9, 0);
      probe("R10 absolute src", 1, 2'b11, 9, 0);
    end
  endtask

  task automatic t_direct_src;
    put_dst(1, 2'b01, 21);
    probe("R6 equal regs", 1, 2'b01, 21, 1);
    probe("R6 differing regs", 1, 2'b01, 20, 0);
    put_dst(1, 2'b10, 21);
    probe("R7 vs displaced dst", 1, 2'b01, 21, 0);
    put_dst(1, 2'b11, 21);
    probe("R7 vs absolute dst", 1, 2'b01, 21, 0);
    put_dst(1, 2'b00, 21);
    probe("R7 vs immediate dst", 1, 2'b01, 21, 0);
  endtask

  task automatic t_displaced_src;
    put_dst(1, 2'b01, 31);
    probe("R8 base equals dst", 1, 2'b10, 31, 1);
    probe("R8 base differs", 1, 2'b10, 0, 0);
    put_dst(1, 2'b11, 31);
    probe("R8 vs absolute dst", 1, 2'b10, 31, 0);
    put_dst(1, 2'b00, 31);
    probe("R8 vs immediate dst", 1, 2'b10, 31, 0);
    put_dst(1, 2'b10, 4);
    probe("R9 unrelated regs", 1, 2'b10, 17, 1);
    probe("R9 same regs", 1, 2'b10, 4, 1);
    put_dst(1, 2'b10, 0);
    probe("R9 reg zero vs max", 1, 2'b10, 31, 1);
  endtask

  task automatic t_comb;
    put_dst(1, 2'b01, 12);
    @(posedge clk); #2;
    probe("R11 same cycle hit", 1, 2'b01, 12, 1);
    probe("R11 same cycle miss", 1, 2'b01, 11, 0);
    probe("R11 same cycle hit again", 1, 2'b10, 12, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_capture_hold();
    t_absent();
    t_imm_abs();
    t_direct_src();
    t_displaced_src();
    t_comb();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule